// File: doc/BRIEF.md
# Multichannel CRC64 Signature Engine

The engine compresses a stream of 64-bit words into a 64-bit cyclic redundancy signature. It keeps a separate signature register for each channel. Software reaches it through a plain register bus: a byte address, write data, a write strobe, a read strobe and 64-bit read data. Each channel has a 2-bit mode field, a software clear bit and a signature register. In full-CPU mode, a write to a channel's signature register folds the written word into the running CRC in one clock. In capture mode, the same write stores the word as is, which lets software seed a signature before it switches the channel back to folding.

The CRC uses the generator x^64 + x^4 + x^3 + x + 1 (feedback constant 0x1b). Each word is taken big-endian: its top byte is the first data byte, and every byte is consumed most significant bit first. One global power-down bit freezes every signature against bus writes. The register bus has no back-pressure. A write takes effect at the clock edge where the write strobe is sampled high. A read returns data in the following cycle, and the master never waits.

Top module: `crcsig_engine`

## Requirements
- R1: After reset, every signature register, the clear register (0x00), the power register (0x08) and the mode register (0x10) read as zero, so every channel starts in capture mode.
- R2: In mode 3 (full-CPU), a signature write replaces signature S with the result of 64 serial steps over the word, bit 63 first. Each step shifts S left by one and XORs in 0x1b when the old top bit of S XOR the data bit is 1. Writing 0x0000000000000001 into a zero signature gives 0x000000000000001b.
- R3: In mode 0 (capture), a signature write loads the written word verbatim.
- R4: In mode 1 or mode 2, signature writes leave the signature unchanged.
- R5: Bit (n-1)*8 of register 0x00 clears channel n. While the bit is set, the signature is held at zero and writes to it are ignored. After the bit is cleared, the signature stays zero until the next write. Other channels are unaffected.
- R6: While bit 0 of register 0x08 is 1, signature writes are ignored in every mode.
- R7: Channel n's mode is bits (n-1)*8+1:(n-1)*8 of register 0x10. Signature registers sit at 0x60, 0xA0, 0xE0 and 0x120. Control reads return only the defined bits and return zero in all other bits.
- R8: A read of any unmapped address returns zero.
- R9: The read data is registered. It shows the addressed value in the cycle after the read strobe and is zero in a cycle that follows no read.
- R10: A write to one channel's signature register leaves every other channel's signature unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_rdata | output | 64 | Read data, valid the cycle after the read strobe |

## Verification
The hardest state to reach is a seeded signature that is then folded: capture mode, the clear bit and full-CPU mode all have to be sequenced through the control registers. The bench writes a seed in capture mode, switches the channel to mode 3 and folds further words. It then compares the result against its own byte-serial model, started from the same seed. The clear sequence is run on one channel while another channel holds a known value, which shows that the clear is confined to its own channel.

// File: rtl/crcsig_pkg.sv
package crcsig_pkg;
  localparam int unsigned SIG_W    = 64;
  localparam logic [SIG_W-1:0] GEN_POLY = 64'h0000_0000_0000_001b;
  localparam int unsigned FIELD_STRIDE = 8;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_AUTO    = 2'd1,
    MODE_SEMI    = 2'd2,
    MODE_FULL    = 2'd3
  } chan_mode_e;
endpackage

// File: rtl/crcsig_fold.sv
// Parallel form of W serial shift steps: the data word is consumed from its MSB down.
module crcsig_fold #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] POLY = 64'h1b
) (
  input  logic [W-1:0] sig_in,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] sig_out
);
  always_comb begin
    logic [W-1:0] acc;
    logic         fb;
    acc = sig_in;
    for (int i = W - 1; i >= 0; i--) begin
      fb  = acc[W-1] ^ word_in[i];
      acc = {acc[W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    sig_out = acc;
  end
endmodule

// File: rtl/crcsig_channel.sv
module crcsig_channel
  import crcsig_pkg::*;
#(
  parameter int unsigned W = SIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         clr,
  input  logic         pdn,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sig
);
  logic [W-1:0] folded;

  crcsig_fold #(.W(W), .POLY(GEN_POLY[W-1:0])) u_fold (
    .sig_in  (sig),
    .word_in (wdata),
    .sig_out (folded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (clr) begin
      sig <= '0;
    end else if (wr && !pdn) begin
      case (mode)
        MODE_CAPTURE: sig <= wdata;
        MODE_FULL:    sig <= folded;
        default:      sig <= sig;
      endcase
    end
  end

  // R5
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0));
  // R6
  a_r6_pdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn && !clr) |=> $stable(sig));
  // R4
  a_r4_idle_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_AUTO || mode == MODE_SEMI) && !clr) |=> $stable(sig));
  // R3
  a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pdn && !clr && mode == MODE_CAPTURE) |=> (sig == $past(wdata)));
  // R10: without a write or clear the signature does not move
  a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !clr) |=> $stable(sig));
endmodule

// File: rtl/crcsig_engine.sv
module crcsig_engine
  import crcsig_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned CLR_OFF    = 'h00,
  parameter int unsigned PWR_OFF    = 'h08,
  parameter int unsigned MODE_OFF   = 'h10,
  parameter int unsigned SIG_BASE   = 'h60,
  parameter int unsigned SIG_STRIDE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [63:0]       bus_rdata
);
  localparam int unsigned DW = SIG_W;

  logic [NCH-1:0]   clr_q;
  logic             pdn_q;
  logic [1:0]       mode_q [NCH];
  logic [NCH-1:0]   ch_hit;
  logic [DW-1:0]    ch_sig [NCH];

  logic hit_clr, hit_pwr, hit_mode;
  assign hit_clr  = (bus_addr == CLR_OFF[ADDR_W-1:0]);
  assign hit_pwr  = (bus_addr == PWR_OFF[ADDR_W-1:0]);
  assign hit_mode = (bus_addr == MODE_OFF[ADDR_W-1:0]);

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      pdn_q <= 1'b0;
      for (int n = 0; n < NCH; n++) mode_q[n] <= 2'd0;
    end else if (bus_wr) begin
      if (hit_pwr) pdn_q <= bus_wdata[0];
      for (int n = 0; n < NCH; n++) begin
        if (hit_clr)  clr_q[n]  <= bus_wdata[n*FIELD_STRIDE];
        if (hit_mode) mode_q[n] <= bus_wdata[n*FIELD_STRIDE +: 2];
      end
    end
  end

  // Channels
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned OFF = SIG_BASE + g * SIG_STRIDE;
    assign ch_hit[g] = (bus_addr == OFF[ADDR_W-1:0]);

    crcsig_channel #(.W(DW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q[g]),
      .clr   (clr_q[g]),
      .pdn   (pdn_q),
      .wr    (bus_wr && ch_hit[g]),
      .wdata (bus_wdata),
      .sig   (ch_sig[g])
    );
  end

  // Read path
  logic [63:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_clr) begin
      for (int n = 0; n < NCH; n++) rd_mux[n*FIELD_STRIDE] = clr_q[n];
    end else if (hit_pwr) begin
      rd_mux[0] = pdn_q;
    end else if (hit_mode) begin
      for (int n = 0; n < NCH; n++) rd_mux[n*FIELD_STRIDE +: 2] = mode_q[n];
    end else begin
      for (int n = 0; n < NCH; n++)
        if (ch_hit[n]) rd_mux = ch_sig[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_mux : '0;
  end

  // R9
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  // R8
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_clr && !hit_pwr && !hit_mode && (ch_hit == '0)) |=> (bus_rdata == '0));
  // R7: address decode selects at most one signature
  a_r7_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit));
endmodule

// File: tb/sim_crcsig_engine.sv
module sim_crcsig_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [63:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crcsig_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  localparam logic [8:0] A_CLR = 9'h000, A_PWR = 9'h008, A_MODE = 9'h010;
  localparam logic [8:0] A_S1 = 9'h060, A_S2 = 9'h0A0, A_S3 = 9'h0E0, A_S4 = 9'h120;

  localparam logic [63:0] VEC [8] = '{
    64'h0000_0000_0000_0001, 64'h0123_4567_89AB_CDEF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000,
    64'h5A5A_A5A5_3C3C_C3C3, 64'h0102_0408_1020_4080
  };

  function automatic logic [63:0] model_fold(input logic [63:0] s, input logic [63:0] w);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] byt;
      byt = w[63 - 8*b -: 8];
      for (int j = 0; j < 8; j++) begin
        logic top;
        top = s[63];
        s = s << 1;
        if ((byt & (8'h80 >> j)) != 0) top = ~top;
        if (top) s = s ^ 64'h1b;
      end
    end
    return s;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [8:0] a, input logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp1, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd("R1 sig1", A_S1, 64'h0);
    chk_rd("R1 sig4", A_S4, 64'h0);
    chk_rd("R1 clr", A_CLR, 64'h0);
    chk_rd("R1 pwr", A_PWR, 64'h0);
    chk_rd("R1 mode", A_MODE, 64'h0);

    // R9 idle read data zero
    @(negedge clk);
    check("R9 idle", bus_rdata, 64'h0);

    // R3 capture (reset mode 0)
    wr(A_S2, 64'h1122_3344_5566_7788);
    chk_rd("R3 capture", A_S2, 64'h1122_3344_5566_7788);

    // R2 full-CPU on all channels; known value
    wr(A_MODE, 64'h0000_0000_0303_0303);
    chk_rd("R7 mode readback", A_MODE, 64'h0000_0000_0303_0303);
    wr(A_S3, 64'h1);
    chk_rd("R2 known 0x1b", A_S3, 64'h1b);

    // R2 table walk on channel 1
    exp1 = 64'h0;
    for (int k = 0; k < 8; k++) begin
      wr(A_S1, VEC[k]);
      exp1 = model_fold(exp1, VEC[k]);
      chk_rd("R2 fold vector", A_S1, exp1);
    end

    // R10 ch1 writes left ch2/ch3 alone
    chk_rd("R10 ch2 untouched", A_S2, 64'h1122_3344_5566_7788);
    chk_rd("R10 ch3 untouched", A_S3, 64'h1b);

    // Seed through capture then fold (R3 then R2)
    wr(A_MODE, 64'h0000_0000_0303_0300);
    wr(A_S1, 64'hA5A5_0000_FFFF_1234);
    wr(A_MODE, 64'h0000_0000_0303_0303);
    wr(A_S1, 64'hCAFE_BABE_0000_0001);
    chk_rd("R2 seeded fold", A_S1, model_fold(64'hA5A5_0000_FFFF_1234, 64'hCAFE_BABE_0000_0001));
    exp1 = model_fold(64'hA5A5_0000_FFFF_1234, 64'hCAFE_BABE_0000_0001);

    // R4 modes 1 and 2 hold
    wr(A_MODE, 64'h0000_0000_0303_0103);
    wr(A_S2, 64'hFFFF_0000_FFFF_0000);
    chk_rd("R4 mode1 hold", A_S2, 64'h1122_3344_5566_7788);
    wr(A_MODE, 64'h0000_0000_0303_0203);
    wr(A_S2, 64'h0);
    chk_rd("R4 mode2 hold", A_S2, 64'h1122_3344_5566_7788);

    // R6 power-down ignores writes in fold and capture
    wr(A_PWR, 64'h1);
    chk_rd("R7 pwr readback", A_PWR, 64'h1);
    wr(A_S1, 64'h1234);
    chk_rd("R6 pdn fold ignored", A_S1, exp1);
    wr(A_MODE, 64'h0000_0000_0303_0300);
    wr(A_S1, 64'h9999);
    chk_rd("R6 pdn capture ignored", A_S1, exp1);
    wr(A_PWR, 64'h0);

    // R5 clear channel 2 only; write during clear ignored
    wr(A_CLR, 64'h0000_0000_0000_0100);
    chk_rd("R7 clr readback", A_CLR, 64'h0000_0000_0000_0100);
    wr(A_MODE, 64'h0000_0000_0303_0000);
    wr(A_S2, 64'h7777);
    chk_rd("R5 held zero", A_S2, 64'h0);
    wr(A_CLR, 64'h0);
    chk_rd("R5 zero after clear", A_S2, 64'h0);
    chk_rd("R5 ch1 unaffected", A_S1, exp1);
    chk_rd("R5 ch3 unaffected", A_S3, 64'h1b);

    // R8 unmapped reads
    chk_rd("R8 unmapped 0x18", 9'h018, 64'h0);
    chk_rd("R8 unmapped 0x68", 9'h068, 64'h0);
    chk_rd("R8 unmapped 0x1F8", 9'h1F8, 64'h0);

    // R7 undefined control bits read zero
    wr(A_MODE, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_rd("R7 mode mask", A_MODE, 64'h0000_0000_0303_0303);
    wr(A_CLR, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_rd("R7 clr mask", A_CLR, 64'h0000_0000_0101_0101);
    chk_rd("R5 all cleared", A_S4, 64'h0);
    wr(A_CLR, 64'h0);
    chk_rd("R5 ch1 cleared", A_S1, 64'h0);

    // R9 read latency: value appears only in cycle after strobe
    wr(A_MODE, 64'h0);
    wr(A_S4, 64'hBEEF);
    @(negedge clk);
    bus_addr = A_S4; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    check("R9 data after strobe", d, 64'hBEEF);
    @(negedge clk);
    check("R9 zero after", bus_rdata, 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule